// File: doc/BRIEF.md
# Push-Button Settling Filter

A mechanical push button does not switch cleanly. Its contact chatters for several milliseconds on press and on release. This block takes that raw contact level and produces a clean level that is synchronous to the system clock.

Two registers in series sample the raw input on every rising clock edge. The block compares their outputs. Any difference means the input moved between samples, and it clears a settling counter. While the two samples agree, the counter counts up. Once the top bit of the counter is set, the counter holds there, and an output register copies the older sample on every edge. Chatter that is shorter than the settling interval therefore never reaches the output.

The counter width `CNT_W` sets the settling interval: 2^(CNT_W-1) agreeing cycles. With the default `CNT_W = 20` and a 50 MHz clock, this is about 10.5 ms.

Reset is asynchronous and active low. The reset source must release it in step with the clock.

Top module: `push_debounce`

## Requirements
- R1: While `rst_n` is low, `btn_clean` is 0. This holds immediately when reset is asserted, whatever the raw input does.
- R2: Let SETTLE = 2^(CNT_W-1). Suppose `btn_raw` has the same value at SETTLE+1 consecutive rising edges. Then `btn_clean` takes that value at the second rising edge after the last of those edges, and not later.
- R3: A level on `btn_raw` that is held for fewer than SETTLE+1 consecutive sampling edges never changes `btn_clean`.
- R4: Any disagreement between the two consecutive samples restarts the settling count from zero. Two sub-threshold runs of the same level, separated by a single opposite sample, do not add up and leave `btn_clean` unchanged.
- R5: Once settled, the counter stops at its top bit and does not wrap. An input held steady for much longer than 2^CNT_W cycles keeps `btn_clean` steady. A later short glitch is still rejected.
- R6: `btn_clean` changes only at rising clock edges that follow a settled count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| btn_raw | input | 1 | Raw contact level from the push button |
| btn_clean | output | 1 | Debounced level |

## Verification
The bench builds the block with `CNT_W = 4`. This gives a settling interval of 8 agreeing cycles, so a level is accepted after 9 identical samples. At that size the exact acceptance edge, runs one cycle short of it, restarted runs, and holds far beyond the counter range (so that a wrap would show up) all fit into a few hundred cycles. Random bursts of chatter with lengths around the threshold then exercise the boundary many times, against a reference built on run lengths.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

  // Pair of consecutive samples taken from the raw contact input.
  typedef struct packed {
    logic newer;
    logic older;
  } pbd_samples_t;

endpackage

// File: rtl/pbd_sampler.sv
module pbd_sampler
  import pbd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         raw_in,
  output pbd_samples_t smp,
  output logic         moved
);

  pbd_samples_t smp_q;
  pbd_samples_t smp_d;

  always_comb begin
    smp_d.newer = raw_in;
    smp_d.older = smp_q.newer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else begin
      smp_q <= smp_d;
    end
  end

  assign smp   = smp_q;
  assign moved = smp_q.newer ^ smp_q.older;

endmodule

// File: rtl/pbd_settle.sv
module pbd_settle #(
  parameter int unsigned CNT_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic moved,
  output logic settled
);

  localparam int unsigned TOP = CNT_W - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = moved | ~cnt_q[TOP];
    if (moved) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign settled = cnt_q[TOP];

  AST_CLEAR_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> (cnt_q == '0)); // R4

  AST_COUNT_WHILE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!moved && !cnt_q[TOP]) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!moved && cnt_q[TOP]) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/pbd_hold.sv
module pbd_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic din,
  output logic dout
);

  logic out_q;
  logic out_d;

  always_comb begin
    out_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (load) begin
      out_q <= out_d;
    end
  end

  assign dout = out_q;

  AST_FROZEN_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout)); // R3

endmodule

// File: rtl/push_debounce.sv
module push_debounce
  import pbd_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic btn_clean
);

  pbd_samples_t smp;
  logic         moved;
  logic         settled;

  pbd_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (btn_raw),
    .smp    (smp),
    .moved  (moved)
  );

  pbd_settle #(
    .CNT_W (CNT_W)
  ) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .moved   (moved),
    .settled (settled)
  );

  pbd_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (settled),
    .din   (smp.older),
    .dout  (btn_clean)
  );

  AST_OUT_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    settled |=> (btn_clean == $past(smp.older))); // R2

  AST_CHANGE_NEEDS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_clean != $past(btn_clean)) |-> $past(settled)); // R6

endmodule

// File: tb/push_debounce_test.sv
module push_debounce_test;

  localparam int unsigned CNT_W  = 4;
  localparam int unsigned RUN    = (1 << (CNT_W - 1)) + 1;
  localparam time         PERIOD = 10ns;

  logic clk;
  logic rst_n;
  logic btn_raw;
  logic btn_clean;

  int checks;
  int errors;

  // reference state, built from sample run lengths only
  int   run_len;
  logic run_lvl;
  logic p1_v, p1_b, p2_v, p2_b;
  logic exp_out;

  push_debounce #(.CNT_W(CNT_W)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .btn_raw   (btn_raw),
    .btn_clean (btn_clean)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic logic accepted(input int len);
    return len >= RUN;
  endfunction

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: btn_clean=%0b expected=%0b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic model_reset();
    run_len = 0;
    run_lvl = 1'b0;
    p1_v = 1'b0; p1_b = 1'b0;
    p2_v = 1'b0; p2_b = 1'b0;
    exp_out = 1'b0;
  endtask

  // Drive one sample at the falling edge, let the rising edge take it, check at the next falling edge.
  task automatic step(input logic b, input string req);
    btn_raw = b;
    @(posedge clk);
    if (b === run_lvl && run_len > 0) begin
      if (run_len < RUN) run_len++;
    end else begin
      run_len = 1;
      run_lvl = b;
    end
    if (p2_v) exp_out = p2_b;
    p2_v = p1_v; p2_b = p1_b;
    p1_v = accepted(run_len); p1_b = b;
    @(negedge clk);
    check(req, btn_clean, exp_out);
  endtask

  task automatic hold(input logic b, input int n, input string req);
    for (int i = 0; i < n; i++) step(b, req);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    void'($urandom(32'd2024));
    model_reset();
    rst_n   = 1'b0;
    btn_raw = 1'b0;

    // R1: reset state, raw input high during reset
    repeat (2) @(negedge clk);
    check("R1", btn_clean, 1'b0);
    btn_raw = 1'b1;
    repeat (RUN + 3) @(negedge clk);
    check("R1", btn_clean, 1'b0);
    btn_raw = 1'b0;
    rst_n = 1'b1;

    hold(1'b0, 3, "R1");

    // R3: one sample short of the threshold
    hold(1'b1, RUN - 1, "R3");
    hold(1'b0, 4, "R3");
    check("R3", btn_clean, 1'b0);

    // R2: exactly the threshold, output rises two edges after the last one
    hold(1'b1, RUN, "R2");
    step(1'b0, "R2");
    check("R2", btn_clean, 1'b0);
    step(1'b0, "R2");
    check("R2", btn_clean, 1'b1);
    hold(1'b1, 4, "R2");

    // R4: two near-threshold runs split by a single opposite sample
    hold(1'b0, RUN - 2, "R4");
    step(1'b1, "R4");
    hold(1'b0, RUN - 2, "R4");
    step(1'b1, "R4");
    check("R4", btn_clean, 1'b1);
    hold(1'b1, 3, "R4");

    // R5: hold far past the counter range, then a short glitch
    hold(1'b1, 8 * (1 << CNT_W), "R5");
    hold(1'b0, RUN - 1, "R5");
    hold(1'b1, 3, "R5");
    check("R5", btn_clean, 1'b1);

    // R2: release accepted after a clean low run
    hold(1'b0, RUN + 2, "R2");
    check("R2", btn_clean, 1'b0);

    // R1: reset asserted while the output is high
    hold(1'b1, RUN + 3, "R1");
    check("R1", btn_clean, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1", btn_clean, 1'b0);
    model_reset();
    btn_raw = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;

    // R6 and R2/R3: random chatter with burst lengths around the threshold
    for (int s = 0; s < 300; s++) begin
      logic lvl;
      int   len;
      lvl = 1'($urandom % 2);
      len = 1 + int'($urandom % (2 * RUN));
      hold(lvl, len, "R6");
    end

    finish_run();
  end

endmodule